// File: doc/BRIEF.md
# Timed Exposure Run Controller

This block opens and closes acquisition windows, called exposure runs, for a particle detector readout. The host loads a duration in milliseconds and issues a start command. The run then begins at once, or it waits for the next rising edge of an external sync input, which may come at any phase. A prescaler on the reference clock produces one tick per millisecond. A millisecond counter ends the run after exactly the programmed number of ticks. While a run is active the event-enable output is high, and downstream logic uses it to gate event forwarding.

When a run ends, the block raises a sticky completion flag for the host. In the same cycle it starts a sync-out pulse of a fixed number of clock cycles. The host can program a sequence of several runs. After the first run, each later run waits for a fresh rising edge on the sync input, so the host does not have to act between runs. A host abort returns the block to idle at once. A zero duration is refused and flagged as an error.

Top module: `exposure_ctrl`

## Requirements
- R1: After reset, `evt_en_o`, `busy_o`, `sync_o`, `done_o` and `err_o` are all low.
- R2: A start with `wait_sync_i` low and a nonzero duration D drives `evt_en_o` high from the cycle after the start. It stays high for exactly D*CLK_PER_MS cycles.
- R3: A start with `wait_sync_i` high keeps `evt_en_o` low and `busy_o` high until `sync_i` rises. `sync_i` passes through two synchronising flops and an edge detector, so `evt_en_o` goes high in the third cycle after the rising edge.
- R4: When a run ends normally, `sync_o` goes high in the cycle in which `evt_en_o` falls and stays high for exactly PULSE_CYC cycles. At the end of the last run of a sequence, `done_o` is set.
- R5: With `seq_len_i` = N > 1, N runs execute. Each run after the first waits for a new rising edge of `sync_i`, and a sync input held high does not start another run. Every run ends with a sync-out pulse. `done_o` stays low until the last run ends, and `busy_o` then drops. A value of 0 in `seq_len_i` means one run.
- R6: A start with a duration of 0 sets `err_o` and leaves the block idle. The next start with a nonzero duration clears `err_o`.
- R7: `abort_i` returns the block to idle in the next cycle, from the wait state or a running state. No sync-out pulse follows, `done_o` is not set, and a later sync edge starts nothing.
- R8: A start issued while the block is busy is ignored.
- R9: `done_o` is cleared by the next start that the block accepts.
- R10: The duration, wait mode and sequence length are captured at the start command. Changes on those inputs during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host start command, one cycle |
| abort_i | input | 1 | Host abort command, one cycle |
| dur_ms_i | input | DUR_W | Run duration in milliseconds |
| wait_sync_i | input | 1 | First run waits for a sync-in edge |
| seq_len_i | input | SEQ_W | Number of runs in the sequence (0 means 1) |
| sync_i | input | 1 | External sync input, asynchronous |
| evt_en_o | output | 1 | Event gate, high while a run is active |
| busy_o | output | 1 | Block is waiting or running |
| done_o | output | 1 | Sticky end-of-sequence flag |
| err_o | output | 1 | Sticky zero-duration error flag |
| sync_o | output | 1 | End-of-run pulse output |

## Verification
The bench sweeps durations from the shortest up to the largest value the small test configuration allows. It checks that the gate width equals the duration times the tick period to the exact cycle, so an off-by-one in the prescaler or millisecond compare shows up as a window one tick or one cycle too long or too short. It measures the three-cycle latency from a sync edge to the gate opening, and it holds the sync input high between sequenced runs to catch a design that triggers on level rather than on the edge. Abort in both the wait and run states, a restart attempt mid-run with a changed duration, and a zero-duration start each target a design that would emit a stray pulse, set the wrong flag, or re-latch its settings.

// File: rtl/exposure_pkg.sv
package exposure_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } expo_state_e;
endpackage

// File: rtl/expo_sync_edge.sv
module expo_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/expo_ms_timer.sv
module expo_ms_timer #(
  parameter int CLK_PER_MS = 100000,
  parameter int DUR_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [DUR_W-1:0] limit_i,
  output logic             expire_o
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [DUR_W-1:0] ms_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      ms_q  <= ms_q + DUR_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  // last tick of the final millisecond
  assign expire_o = !clear_i && tick && (ms_q == limit_i - DUR_W'(1));
endmodule

// File: rtl/expo_pulse_gen.sv
module expo_pulse_gen #(
  parameter int PULSE_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic kill_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (kill_i)          cnt_q <= '0;
    else if (fire_i)          cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/exposure_ctrl.sv
module exposure_ctrl
  import exposure_pkg::*;
#(
  parameter int CLK_PER_MS = 100000,
  parameter int DUR_W      = 32,
  parameter int PULSE_CYC  = 100,
  parameter int SEQ_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DUR_W-1:0] dur_ms_i,
  input  logic             wait_sync_i,
  input  logic [SEQ_W-1:0] seq_len_i,
  input  logic             sync_i,
  output logic             evt_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             sync_o
);
  expo_state_e      state_q;
  logic [DUR_W-1:0] dur_q;
  logic [SEQ_W-1:0] runs_left_q;
  logic             done_q, err_q;
  logic             sync_rise, expire;

  expo_sync_edge u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_i),
    .rise_o  (sync_rise)
  );

  expo_ms_timer #(
    .CLK_PER_MS (CLK_PER_MS),
    .DUR_W      (DUR_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_q != ST_RUN),
    .limit_i  (dur_q),
    .expire_o (expire)
  );

  expo_pulse_gen #(
    .PULSE_CYC (PULSE_CYC)
  ) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (expire),
    .kill_i  (abort_i),
    .pulse_o (sync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      dur_q       <= DUR_W'(1);
      runs_left_q <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          done_q <= 1'b0;
          if (dur_ms_i == '0) begin
            err_q <= 1'b1;
          end else begin
            err_q       <= 1'b0;
            dur_q       <= dur_ms_i;
            runs_left_q <= (seq_len_i == '0) ? SEQ_W'(1) : seq_len_i;
            state_q     <= wait_sync_i ? ST_ARM : ST_RUN;
          end
        end
        ST_ARM: if (sync_rise) state_q <= ST_RUN;
        ST_RUN: if (expire) begin
          if (runs_left_q > SEQ_W'(1)) begin
            runs_left_q <= runs_left_q - SEQ_W'(1);
            state_q     <= ST_ARM;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign evt_en_o = (state_q == ST_RUN);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/exposure_ctrl_chk.sv
module exposure_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic abort_i,
  input logic evt_en_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic sync_o
);
  assert_en_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_en_o |-> busy_o);

  assert_end_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(evt_en_o) && !$past(abort_i)) |-> sync_o);

  assert_done_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(evt_en_o));

  assert_err_from_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(start_i));

  assert_abort_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !evt_en_o && !sync_o));

  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && evt_en_o && !abort_i) |=> (busy_o && !err_o));
endmodule

bind exposure_ctrl exposure_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .abort_i  (abort_i),
  .evt_en_o (evt_en_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .sync_o   (sync_o)
);

// File: tb/exposure_ctrl_tb_top.sv
module exposure_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P     = 4;
  localparam int PW    = 3;
  localparam int DW    = 8;
  localparam int SW    = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0, wait_sync_i = 1'b0, sync_i = 1'b0;
  logic [DW-1:0] dur_ms_i = '0;
  logic [SW-1:0] seq_len_i = '0;
  logic evt_en_o, busy_o, done_o, err_o, sync_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exposure_ctrl #(.CLK_PER_MS(P), .DUR_W(DW), .PULSE_CYC(PW), .SEQ_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .dur_ms_i(dur_ms_i), .wait_sync_i(wait_sync_i), .seq_len_i(seq_len_i),
    .sync_i(sync_i), .evt_en_o(evt_en_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .sync_o(sync_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int d, input bit ws, input int sl);
    @(negedge clk);
    dur_ms_i = DW'(d); wait_sync_i = ws; seq_len_i = SW'(sl); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // counts gate cycles from the current sample, then the pulse width
  task automatic measure(output int en_cnt, output int sc, output bit pulse_at_fall);
    en_cnt = 0; sc = 0;
    while (evt_en_o) begin en_cnt++; @(negedge clk); end
    pulse_at_fall = sync_o;
    while (sync_o) begin sc++; @(negedge clk); end
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!evt_en_o && n < 50);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int ec, sc, n; bit pf;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk({evt_en_o, busy_o, sync_o, done_o, err_o} == 5'b0, "R1 reset state",
        int'({evt_en_o, busy_o, sync_o, done_o, err_o}), 0);

    // R2 R4 R9 immediate sweep
    for (int d = 1; d <= 6; d++) begin
      do_start(d, 1'b0, 1);
      chk(done_o == 1'b0, "R9 done cleared", done_o, 0);
      measure(ec, sc, pf);
      chk(ec == d*P, "R2 gate width", ec, d*P);
      chk(pf, "R4 pulse at gate fall", pf, 1);
      chk(sc == PW, "R4 pulse width", sc, PW);
      chk(done_o && !busy_o, "R4 done set", done_o, 1);
    end
    do_start(255, 1'b0, 0);
    measure(ec, sc, pf);
    chk(ec == 255*P, "R2 max duration", ec, 255*P);
    chk(sc == PW && done_o, "R4 max duration end", sc, PW);

    // R3 armed start
    do_start(3, 1'b1, 1);
    n = 0;
    repeat (8) begin @(negedge clk); if (evt_en_o || !busy_o) n++; end
    chk(n == 0, "R3 waits for sync", n, 0);
    sync_i = 1'b1;
    wait_rise(n);
    chk(n == 3, "R3 sync latency", n, 3);
    measure(ec, sc, pf);
    chk(ec == 3*P, "R3 armed gate width", ec, 3*P);
    chk(sc == PW && done_o, "R4 armed end", sc, PW);
    sync_i = 1'b0;
    repeat (3) @(negedge clk);

    // R5 sequence of three
    do_start(2, 1'b0, 3);
    measure(ec, sc, pf);
    chk(ec == 2*P && sc == PW, "R5 run1", ec, 2*P);
    chk(!done_o && busy_o, "R5 not done after run1", done_o, 0);
    sync_i = 1'b1;
    wait_rise(n);
    chk(n == 3, "R5 run2 latency", n, 3);
    measure(ec, sc, pf);
    chk(ec == 2*P && sc == PW && pf, "R5 run2", ec, 2*P);
    n = 0;
    repeat (10) begin @(negedge clk); if (evt_en_o || !busy_o) n++; end
    chk(n == 0, "R5 held sync no start", n, 0);
    chk(!done_o, "R5 done after run2", done_o, 0);
    sync_i = 1'b0;
    repeat (3) @(negedge clk);
    sync_i = 1'b1;
    wait_rise(n);
    measure(ec, sc, pf);
    chk(ec == 2*P && sc == PW, "R5 run3", ec, 2*P);
    chk(done_o && !busy_o, "R5 done after last", done_o, 1);
    sync_i = 1'b0;

    // R6 zero duration
    do_start(0, 1'b0, 1);
    chk(err_o && !busy_o && !evt_en_o, "R6 zero rejected", err_o, 1);
    repeat (4) @(negedge clk);
    chk(!busy_o, "R6 stays idle", busy_o, 0);
    do_start(1, 1'b0, 1);
    chk(!err_o, "R6 err cleared", err_o, 0);
    measure(ec, sc, pf);
    chk(ec == P, "R6 valid run after error", ec, P);

    // R7 abort while running
    do_start(5, 1'b0, 1);
    repeat (6) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(!busy_o && !evt_en_o, "R7 abort idle", busy_o, 0);
    n = 0;
    repeat (25) begin @(negedge clk); if (sync_o || done_o || evt_en_o) n++; end
    chk(n == 0, "R7 no pulse no done", n, 0);

    // R7 abort while armed
    do_start(2, 1'b1, 1);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(!busy_o, "R7 abort armed", busy_o, 0);
    sync_i = 1'b1;
    n = 0;
    repeat (8) begin @(negedge clk); if (evt_en_o || busy_o) n++; end
    chk(n == 0, "R7 sync after abort ignored", n, 0);
    sync_i = 1'b0;

    // R8 R10 start while busy with changed inputs
    do_start(4, 1'b0, 1);
    repeat (3) @(negedge clk);
    dur_ms_i = DW'(1); seq_len_i = SW'(3); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    measure(ec, sc, pf);
    chk(ec + 4 == 4*P, "R8 R10 restart ignored", ec + 4, 4*P);
    chk(done_o && !busy_o && !err_o, "R10 single run kept", busy_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule